// File: doc/BRIEF.md
# DDR SDRAM Command Decoder with Bank and Power Tracking

This block sits on the memory side of a DDR-style SDRAM interface and runs on the rising edge of the true clock. Every cycle it registers chip select, the three command strobes, the bank address, the address bus and the clock enable. It then decodes the registered cycle into one command. It keeps an open or idle record for each bank, together with the row that was opened. From these it drives one-cycle command strobes, the target bank, row and column, the auto-precharge flag, the mode-register load target and the stored mode words.

The block also follows the clock-enable input to report a power state. It uses the per-bank record to tell active power-down apart from precharge power-down and self refresh. Commands that break the bank protocol are dropped and set a sticky error flag. Data-path timing, strobe capture and refresh counting are handled elsewhere.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: Every control and address input is registered on the rising clock edge. A command sampled at edge k drives its strobes and target fields during the cycle that follows edge k. Bank state, mode words, the error flag and the power state change at edge k+1.
- R2: A cycle sampled with `cs_n` high is a deselect. It produces no strobe and changes no bank, mode or error state, whatever the other inputs carry.
- R3: With `cs_n` low, the tuple {`ras_n`,`cas_n`,`we_n`} decodes as follows: 111 is no-op, 011 is ACTIVE, 101 is READ, 100 is WRITE, 010 is PRECHARGE, 001 is AUTO REFRESH and 000 is MODE REGISTER SET. Code 110 is treated as a no-op. At most one strobe is high in any cycle.
- R4: An ACTIVE to an idle bank raises `act_o` and opens that bank, recording the address as its row. `row_o` shows the address bus during any decoded ACTIVE. In every other cycle it shows the last row recorded for the bank on `bank_o`. `bank_open_o[i]` is 1 while bank i is open.
- R5: A READ or WRITE to an open bank raises `rd_o` or `wr_o`. `col_o` carries the address with bit 10 removed. `auto_pre_o` equals address bit 10. When that bit is 1, the bank returns to idle after the access.
- R6: PRECHARGE raises `pre_o`. With address bit 10 low, only the bank named by `ba` closes. With bit 10 high, all banks close and `pre_all_o` is high.
- R7: MODE REGISTER SET raises `mrs_o`, and `mr_sel_o` shows `ba`. With `ba`=0 the address loads `mode_reg_o`, and with `ba`=1 it loads `ext_mode_reg_o`. Other `ba` values load nothing.
- R8: `pwr_state_o` uses the codes 0 normal, 1 precharge power-down, 2 active power-down and 3 self refresh. From normal, a sampled low `cke` enters state 2 if any bank is open. If no bank is open, it enters state 3 when the same cycle carries AUTO REFRESH with `cs_n` low, and state 1 otherwise. From any other state, a sampled high `cke` returns to normal. No command is decoded in a cycle with `cke` sampled low or with the power state not normal.
- R9: A READ or WRITE to an idle bank, or an ACTIVE to an open bank, produces no strobe and changes no bank state. It sets `proto_err_o`, which stays set until reset.
- R10: A synchronous active-high `rst` closes all banks, clears the rows, both mode words and the error flag, and sets the power state to normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | True clock, rising edge used |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command bit |
| cas_n | input | 1 | Column strobe command bit |
| we_n | input | 1 | Write-enable command bit |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address / op-code bus |
| act_o | output | 1 | Accepted ACTIVE |
| rd_o | output | 1 | Accepted READ |
| wr_o | output | 1 | Accepted WRITE |
| pre_o | output | 1 | PRECHARGE decoded |
| pre_all_o | output | 1 | PRECHARGE targets all banks |
| ref_o | output | 1 | AUTO REFRESH decoded |
| mrs_o | output | 1 | MODE REGISTER SET decoded |
| bank_o | output | 2 | Target bank |
| row_o | output | 13 | Row address |
| col_o | output | 12 | Column address (bit 10 removed) |
| auto_pre_o | output | 1 | Auto-precharge on this access |
| mr_sel_o | output | 2 | Mode register target |
| mode_reg_o | output | 13 | Base mode word |
| ext_mode_reg_o | output | 13 | Extended mode word |
| bank_open_o | output | 4 | Per-bank open flags |
| pwr_state_o | output | 2 | Power state |
| proto_err_o | output | 1 | Sticky protocol error |

## Verification
The bench targets the following corner cases:
- A precharge with bit 10 high must close every bank. A decoder that ignores the bit closes only one bank and leaves open flags high.
- An access with auto-precharge must close its bank one edge later. Getting this wrong leaves the bank open, and the next ACTIVE is then wrongly flagged.
- Commands aimed at the wrong bank state must be dropped. A design that still strobes them, or clears the sticky flag, shows up at once.
- A clock-enable drop must select the right power state. A design that ignores the open banks reports precharge power-down where active power-down is due. A design that misses AUTO REFRESH with `cke` low never reaches self refresh.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

   typedef enum logic [2:0] {
      C_NONE = 3'd0,
      C_ACT  = 3'd1,
      C_RD   = 3'd2,
      C_WR   = 3'd3,
      C_PRE  = 3'd4,
      C_REF  = 3'd5,
      C_MRS  = 3'd6
   } cmd_e;

   typedef enum logic [1:0] {
      PS_NORMAL   = 2'd0,
      PS_PRE_PD   = 2'd1,
      PS_ACT_PD   = 2'd2,
      PS_SELF_REF = 2'd3
   } pwr_e;

   // {ras_n, cas_n, we_n} with chip select low
   localparam logic [2:0] RCW_NOP = 3'b111;
   localparam logic [2:0] RCW_ACT = 3'b011;
   localparam logic [2:0] RCW_RD  = 3'b101;
   localparam logic [2:0] RCW_WR  = 3'b100;
   localparam logic [2:0] RCW_PRE = 3'b010;
   localparam logic [2:0] RCW_REF = 3'b001;
   localparam logic [2:0] RCW_MRS = 3'b000;

   function automatic cmd_e rcw_to_cmd(input logic [2:0] rcw);
      cmd_e c;
      case (rcw)
         RCW_ACT: c = C_ACT;
         RCW_RD:  c = C_RD;
         RCW_WR:  c = C_WR;
         RCW_PRE: c = C_PRE;
         RCW_REF: c = C_REF;
         RCW_MRS: c = C_MRS;
         default: c = C_NONE;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/ddr_cmd_capture.sv
module ddr_cmd_capture #(
   parameter int BA_W   = 2,
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cke,
   input  logic              cs_n,
   input  logic [2:0]        rcw,
   input  logic [BA_W-1:0]   ba,
   input  logic [ADDR_W-1:0] addr,
   output logic              cke_q,
   output logic              cs_n_q,
   output logic [2:0]        rcw_q,
   output logic [BA_W-1:0]   ba_q,
   output logic [ADDR_W-1:0] addr_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         cke_q  <= 1'b1;
         cs_n_q <= 1'b1;
         rcw_q  <= 3'b111;
         ba_q   <= '0;
         addr_q <= '0;
      end else begin
         cke_q  <= cke;
         cs_n_q <= cs_n;
         rcw_q  <= rcw;
         ba_q   <= ba;
         addr_q <= addr;
      end
   end

endmodule

// File: rtl/ddr_cmd_classify.sv
module ddr_cmd_classify
   import ddr_cmd_pkg::*;
(
   input  logic       cs_n_q,
   input  logic [2:0] rcw_q,
   input  logic       cke_q,
   input  logic       pwr_normal,
   output cmd_e       cmd,
   output logic       sr_req
);

   logic selected;

   assign selected = !cs_n_q;

   always_comb begin
      if (selected && cke_q && pwr_normal) cmd = rcw_to_cmd(rcw_q);
      else                                 cmd = C_NONE;
   end

   // refresh code presented together with a low clock enable
   assign sr_req = selected && !cke_q && (rcw_q == RCW_REF);

endmodule

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot #(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              open_req,
   input  logic              close_req,
   input  logic [ADDR_W-1:0] row_in,
   output logic              is_open,
   output logic [ADDR_W-1:0] row_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         is_open <= 1'b0;
         row_q   <= '0;
      end else if (open_req) begin
         is_open <= 1'b1;
         row_q   <= row_in;
      end else if (close_req) begin
         is_open <= 1'b0;
      end
   end

   // an open request only ever reaches an idle bank
   assert_open_req_idle_R9: assert property (@(posedge clk) disable iff (rst)
      open_req |-> !is_open);

   assert_open_after_req_R4: assert property (@(posedge clk) disable iff (rst)
      open_req |=> is_open);

endmodule

// File: rtl/ddr_pwr_ctrl.sv
module ddr_pwr_ctrl
   import ddr_cmd_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic cke_q,
   input  logic any_open,
   input  logic sr_req,
   output pwr_e state
);

   pwr_e nxt;

   always_comb begin
      nxt = state;
      if (state == PS_NORMAL) begin
         if (!cke_q) begin
            if (any_open)    nxt = PS_ACT_PD;
            else if (sr_req) nxt = PS_SELF_REF;
            else             nxt = PS_PRE_PD;
         end
      end else if (cke_q) begin
         nxt = PS_NORMAL;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) state <= PS_NORMAL;
      else     state <= nxt;
   end

   assert_sr_from_idle_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(state == PS_SELF_REF) |-> $past(!any_open));

   assert_pd_exit_R8: assert property (@(posedge clk) disable iff (rst)
      (state != PS_NORMAL && cke_q) |=> state == PS_NORMAL);

endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
   import ddr_cmd_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 13,
   parameter int AP_BIT    = 10,
   localparam int BA_W     = $clog2(NUM_BANKS),
   localparam int COL_W    = ADDR_W - 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cke,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BA_W-1:0]   ba,
   input  logic [ADDR_W-1:0] addr,
   output logic              act_o,
   output logic              rd_o,
   output logic              wr_o,
   output logic              pre_o,
   output logic              pre_all_o,
   output logic              ref_o,
   output logic              mrs_o,
   output logic [BA_W-1:0]   bank_o,
   output logic [ADDR_W-1:0] row_o,
   output logic [COL_W-1:0]  col_o,
   output logic              auto_pre_o,
   output logic [BA_W-1:0]   mr_sel_o,
   output logic [ADDR_W-1:0] mode_reg_o,
   output logic [ADDR_W-1:0] ext_mode_reg_o,
   output logic [NUM_BANKS-1:0] bank_open_o,
   output logic [1:0]        pwr_state_o,
   output logic              proto_err_o
);

   if (NUM_BANKS < 2 || NUM_BANKS != (1 << BA_W)) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (AP_BIT < 1 || AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("AP_BIT must lie inside the address bus, above bit 0");
   end

   logic              cke_q, cs_n_q;
   logic [2:0]        rcw_q;
   logic [BA_W-1:0]   ba_q;
   logic [ADDR_W-1:0] addr_q;
   cmd_e              cmd;
   logic              sr_req;
   pwr_e              pwr;
   logic              ap;
   logic              tgt_open;
   logic              act_ok, rd_ok, wr_ok, bad_cmd;
   logic [ADDR_W-1:0] row_tab [NUM_BANKS];
   logic [ADDR_W-1:0] mode_q, emode_q;
   logic              err_q;

   ddr_cmd_capture #(.BA_W(BA_W), .ADDR_W(ADDR_W)) u_cap (
      .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n),
      .rcw({ras_n, cas_n, we_n}), .ba(ba), .addr(addr),
      .cke_q(cke_q), .cs_n_q(cs_n_q), .rcw_q(rcw_q),
      .ba_q(ba_q), .addr_q(addr_q)
   );

   ddr_cmd_classify u_cls (
      .cs_n_q(cs_n_q), .rcw_q(rcw_q), .cke_q(cke_q),
      .pwr_normal(pwr == PS_NORMAL), .cmd(cmd), .sr_req(sr_req)
   );

   assign ap       = addr_q[AP_BIT];
   assign tgt_open = bank_open_o[ba_q];
   assign act_ok   = (cmd == C_ACT) && !tgt_open;
   assign rd_ok    = (cmd == C_RD) && tgt_open;
   assign wr_ok    = (cmd == C_WR) && tgt_open;
   assign bad_cmd  = ((cmd == C_ACT) && tgt_open) ||
                     (((cmd == C_RD) || (cmd == C_WR)) && !tgt_open);

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      logic sel;
      assign sel = (ba_q == BA_W'(i));
      ddr_bank_slot #(.ADDR_W(ADDR_W)) u_slot (
         .clk(clk), .rst(rst),
         .open_req(act_ok && sel),
         .close_req(((cmd == C_PRE) && (ap || sel)) ||
                    ((rd_ok || wr_ok) && sel && ap)),
         .row_in(addr_q),
         .is_open(bank_open_o[i]),
         .row_q(row_tab[i])
      );
   end

   ddr_pwr_ctrl u_pwr (
      .clk(clk), .rst(rst), .cke_q(cke_q), .any_open(|bank_open_o),
      .sr_req(sr_req), .state(pwr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q  <= '0;
         emode_q <= '0;
         err_q   <= 1'b0;
      end else begin
         if (cmd == C_MRS && ba_q == BA_W'(0)) mode_q  <= addr_q;
         if (cmd == C_MRS && ba_q == BA_W'(1)) emode_q <= addr_q;
         if (bad_cmd) err_q <= 1'b1;
      end
   end

   // column field drops the auto-precharge bit; variant depends on its position
   if (AP_BIT == ADDR_W - 1) begin : g_col_top
      assign col_o = addr_q[AP_BIT-1:0];
   end else begin : g_col_mid
      assign col_o = {addr_q[ADDR_W-1:AP_BIT+1], addr_q[AP_BIT-1:0]};
   end

   assign act_o          = act_ok;
   assign rd_o           = rd_ok;
   assign wr_o           = wr_ok;
   assign pre_o          = (cmd == C_PRE);
   assign pre_all_o      = (cmd == C_PRE) && ap;
   assign ref_o          = (cmd == C_REF);
   assign mrs_o          = (cmd == C_MRS);
   assign bank_o         = ba_q;
   assign row_o          = (cmd == C_ACT) ? addr_q : row_tab[ba_q];
   assign auto_pre_o     = (rd_ok || wr_ok) && ap;
   assign mr_sel_o       = ba_q;
   assign mode_reg_o     = mode_q;
   assign ext_mode_reg_o = emode_q;
   assign pwr_state_o    = pwr;
   assign proto_err_o    = err_q;

   assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0({act_o, rd_o, wr_o, pre_o, ref_o, mrs_o}));

   assert_rw_open_bank_R9: assert property (@(posedge clk) disable iff (rst)
      (rd_o || wr_o) |-> bank_open_o[bank_o]);

   assert_act_idle_bank_R9: assert property (@(posedge clk) disable iff (rst)
      act_o |-> !bank_open_o[bank_o]);

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      proto_err_o |=> proto_err_o);

   assert_quiet_in_pd_R8: assert property (@(posedge clk) disable iff (rst)
      (pwr_state_o != 2'd0) |-> !(act_o || rd_o || wr_o || pre_o || ref_o || mrs_o));

   assert_ap_closes_R5: assert property (@(posedge clk) disable iff (rst)
      ((rd_o || wr_o) && auto_pre_o) |=> !bank_open_o[$past(bank_o)]);

   assert_pre_all_closes_R6: assert property (@(posedge clk) disable iff (rst)
      pre_all_o |=> (bank_open_o == '0));

endmodule

// File: tb/sim_ddr_cmd_tracker.sv
module sim_ddr_cmd_tracker;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [12:0] addr = '0;
   logic        act_o, rd_o, wr_o, pre_o, pre_all_o, ref_o, mrs_o, auto_pre_o, proto_err_o;
   logic [1:0]  bank_o, mr_sel_o, pwr_state_o;
   logic [12:0] row_o, mode_reg_o, ext_mode_reg_o;
   logic [11:0] col_o;
   logic [3:0]  bank_open_o;

   int n_vec = 0, n_bad = 0;
   bit started = 0;

   always #10 clk = ~clk;   // 50 MHz

   ddr_cmd_tracker u0 (
      .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .addr(addr), .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o),
      .pre_o(pre_o), .pre_all_o(pre_all_o), .ref_o(ref_o), .mrs_o(mrs_o),
      .bank_o(bank_o), .row_o(row_o), .col_o(col_o), .auto_pre_o(auto_pre_o),
      .mr_sel_o(mr_sel_o), .mode_reg_o(mode_reg_o), .ext_mode_reg_o(ext_mode_reg_o),
      .bank_open_o(bank_open_o), .pwr_state_o(pwr_state_o), .proto_err_o(proto_err_o)
   );

   // ---------------- reference model ----------------
   int q_cs = 1, q_rcw = 7, q_ba = 0, q_addr = 0, q_cke = 1;
   bit m_open [4];
   int m_row  [4];
   int m_mode = 0, m_emode = 0, m_pwr = 0;
   bit m_err = 0;

   // 0 none 1 act 2 rd 3 wr 4 pre 5 ref 6 mrs
   function automatic int m_cmd();
      if (q_cs != 0 || q_cke != 1 || m_pwr != 0) return 0;
      case (q_rcw)
         3: return 1;
         5: return 2;
         4: return 3;
         2: return 4;
         1: return 5;
         0: return 6;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         q_cs = 1; q_rcw = 7; q_ba = 0; q_addr = 0; q_cke = 1;
         for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = 0; end
         m_mode = 0; m_emode = 0; m_pwr = 0; m_err = 0;
      end else begin
         int c, a10;
         bit any;
         c   = m_cmd();
         a10 = (q_addr >> 10) & 1;
         any = m_open[0] | m_open[1] | m_open[2] | m_open[3];
         if (m_pwr == 0) begin
            if (q_cke == 0) m_pwr = any ? 2 : ((q_cs == 0 && q_rcw == 1) ? 3 : 1);
         end else if (q_cke == 1) m_pwr = 0;
         case (c)
            1: if (m_open[q_ba]) m_err = 1; else begin m_open[q_ba] = 1; m_row[q_ba] = q_addr; end
            2, 3: if (!m_open[q_ba]) m_err = 1; else if (a10 == 1) m_open[q_ba] = 0;
            4: if (a10 == 1) begin for (int i = 0; i < 4; i++) m_open[i] = 0; end
               else m_open[q_ba] = 0;
            6: if (q_ba == 0) m_mode = q_addr; else if (q_ba == 1) m_emode = q_addr;
            default: ;
         endcase
         q_cs = cs_n; q_rcw = {ras_n, cas_n, we_n}; q_ba = ba; q_addr = addr; q_cke = cke;
      end
      started = 1;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (started && !rst) begin
         int c, a10;
         bit open_t;
         c      = m_cmd();
         a10    = (q_addr >> 10) & 1;
         open_t = m_open[q_ba];
         chk("R1/R3 act strobe",  act_o, (c == 1 && !open_t));
         chk("R3/R9 rd strobe",   rd_o,  (c == 2 && open_t));
         chk("R3/R9 wr strobe",   wr_o,  (c == 3 && open_t));
         chk("R3 pre strobe",     pre_o, (c == 4));
         chk("R6 pre_all",        pre_all_o, (c == 4 && a10 == 1));
         chk("R2/R3 ref strobe",  ref_o, (c == 5));
         chk("R7 mrs strobe",     mrs_o, (c == 6));
         chk("R4 bank_o",         bank_o, q_ba);
         chk("R4 row_o",          row_o, (c == 1) ? q_addr : m_row[q_ba]);
         chk("R5 col_o",          col_o, ((q_addr >> 11) << 10) | (q_addr & 1023));
         chk("R5 auto_pre",       auto_pre_o, ((c == 2 || c == 3) && open_t && a10 == 1));
         chk("R7 mr_sel",         mr_sel_o, q_ba);
         chk("R7 mode_reg",       mode_reg_o, m_mode);
         chk("R7 ext_mode_reg",   ext_mode_reg_o, m_emode);
         chk("R4 bank_open",      bank_open_o,
             {m_open[3], m_open[2], m_open[1], m_open[0]});
         chk("R8 pwr_state",      pwr_state_o, m_pwr);
         chk("R9 proto_err",      proto_err_o, m_err);
      end
   end

   // ---------------- stimulus ----------------
   task automatic issue(input bit c_n, input bit [2:0] rcw, input int b,
                        input int a, input bit k);
      @(posedge clk); #5;
      cs_n = c_n; {ras_n, cas_n, we_n} = rcw; ba = 2'(b); addr = 13'(a); cke = k;
   endtask

   task automatic nop(input int n, input bit k);
      for (int i = 0; i < n; i++) issue(0, 3'b111, 0, 0, k);
   endtask

   task automatic do_reset();
      @(posedge clk); #5; rst = 1;
      cs_n = 1; cke = 1; {ras_n, cas_n, we_n} = 3'b111;
      repeat (2) @(posedge clk);
      #5 rst = 0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #5 rst = 0;
      @(negedge clk);
      // R10: reset state, values from the requirement
      chk("R10 reset bank_open", bank_open_o, 0);
      chk("R10 reset pwr", pwr_state_o, 0);
      chk("R10 reset err", proto_err_o, 0);
      chk("R10 reset mode", mode_reg_o, 0);

      issue(0, 3'b011, 0, 13'h1ABC, 1);   // ACT b0
      issue(0, 3'b011, 2, 13'h0123, 1);   // ACT b2
      issue(0, 3'b101, 0, 13'h0005, 1);   // READ b0
      issue(0, 3'b100, 2, 13'h0407, 1);   // WRITE b2 auto-precharge (R5)
      issue(0, 3'b101, 2, 13'h0001, 1);   // READ closed b2 -> R9
      issue(0, 3'b011, 0, 13'h0002, 1);   // ACT open b0 -> R9
      issue(1, 3'b011, 1, 13'h0777, 1);   // deselect (R2)
      issue(0, 3'b110, 1, 13'h0000, 1);   // unused code (R3)
      nop(2, 1);
      #5 chk("R2 deselect left bank 1 idle", bank_open_o[1], 0);
      issue(0, 3'b010, 0, 13'h0000, 1);   // PRE b0 single (R6)
      issue(0, 3'b011, 1, 13'h0AAA, 1);
      issue(0, 3'b011, 3, 13'h1555, 1);
      issue(0, 3'b010, 1, 13'h0400, 1);   // PRE all (R6)
      issue(0, 3'b000, 0, 13'h0033, 1);   // MRS base (R7)
      issue(0, 3'b000, 1, 13'h0002, 1);   // MRS ext
      issue(0, 3'b000, 2, 13'h1FFF, 1);   // MRS other: no load
      issue(0, 3'b001, 0, 0, 1);          // REF
      nop(3, 0);                          // idle -> precharge PD (R8)
      issue(0, 3'b011, 1, 13'h0010, 0);   // ignored while down
      nop(2, 1);
      issue(0, 3'b011, 1, 13'h0020, 1);
      nop(3, 0);                          // open -> active PD (R8)
      nop(2, 1);
      issue(0, 3'b010, 0, 13'h0400, 1);
      issue(0, 3'b001, 0, 0, 0);          // self refresh entry (R8)
      nop(4, 0);
      nop(2, 1);
      do_reset();                         // R10 clears sticky error
      nop(1, 1);

      for (int i = 0; i < 4000; i++) begin
         int r;
         bit [2:0] codes [7];
         codes = '{3'b111, 3'b011, 3'b101, 3'b100, 3'b010, 3'b001, 3'b000};
         r = $urandom_range(0, 99);
         issue(r < 8, codes[$urandom_range(0, 6)], $urandom_range(0, 3),
               $urandom_range(0, 8191), ($urandom_range(0, 99) >= 10));
         if (i == 2000) do_reset();
      end
      nop(3, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #3000000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule